// File: doc/BRIEF.md
# Byte/Word Parallel Memory Bus Front End

This block is the device side of an asynchronous parallel nonvolatile memory bus, modelled with a synchronous sampling clock. On every clock it samples the active-low chip-enable, output-enable, write-enable and hardware-reset pins. It sorts them into one of six bus operations: reset, standby, output disable, read, write, or an invalid overlap of read and write strobes.

Reads return data from a small register-array stand-in for the real storage. Writes hand their address and data to a command-capture port, which the command logic behind this block would consume. A width-select pin picks a 16-bit word path or an 8-bit byte path. In byte mode the topmost data pin becomes the lowest address bit. That bit chooses which half of the addressed word reaches the low data lane, and the middle pins stay undriven.

After power-up or a hardware reset the block is in read-array state, so reads need no command first. A status flag shows whether any command has been captured since then.

Top module: `nvm_bus_front`

## Requirements
- R1: A read (chip-enable low, output-enable low, write-enable high, reset high) with the width pin high drives all 16 output enables high on the next clock. dq_out then carries the stand-in word at index `addr mod STUB_DEPTH`, where byte 0 is `index ^ 0x5A` and byte 1 is `index ^ 0xC3`.
- R2: A read with the width pin low enables only data pins 7..0 (enable pattern 0x00FF). dq_out[7:0] is byte 0 of the addressed word when dq_in[15] is 0 and byte 1 when dq_in[15] is 1. dq_out[15:8] is zero.
- R3: With chip-enable low and output-enable high, all output enables are low on the next clock.
- R4: With chip-enable high, all output enables are low on the next clock, whatever the other strobes are.
- R5: With the reset pin low, all output enables are low, cmd_valid is low and cmd_seen is cleared on the next clock, whatever the other strobes are.
- R6: A write (chip-enable low, output-enable high, write-enable low, reset high) raises cmd_valid for exactly one clock, one cycle after the first write cycle. A write held for several clocks yields only one pulse.
- R7: In word mode a captured write gives cmd_addr = {0, addr} and cmd_data = dq_in. In byte mode it gives cmd_addr = {addr, dq_in[15]} and cmd_data = {8'h00, dq_in[7:0]}. Both values hold until the next capture.
- R8: cmd_seen is 0 after power-on reset. It rises on the clock that raises cmd_valid. Reads, standby and output disable never set it.
- R9: The first read after power-on or after a hardware reset returns array data with no preceding command.
- R10: Chip-enable, output-enable and write-enable all low together is neither a read nor a write: no output enables and no capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| hw_rst_n | input | 1 | Hardware reset pin, active low |
| wide_mode | input | 1 | 1 = 16-bit word path, 0 = 8-bit byte path |
| addr | input | 19 | Word address pins |
| dq_in | input | 16 | Data pins as seen by the device; bit 15 is the byte-address LSB in byte mode |
| dq_out | output | 16 | Data the device drives onto the pins |
| dq_oe | output | 16 | Per-pin tri-state enable |
| cmd_valid | output | 1 | One-cycle strobe for a captured write |
| cmd_addr | output | 20 | Captured byte-granular write address |
| cmd_data | output | 16 | Captured write data |
| cmd_seen | output | 1 | A command was captured since the last reset |

## Verification
Word reads are swept over index 0, the last stand-in index, a wrapped index and the top address. This separates correct modulo indexing from a swapped or truncated lane. Byte reads use both values of the pin-15 address bit, so a reversed half select or a leak onto the upper lane shows up. The strobe patterns for standby, output disable, the invalid all-low overlap and reset are interleaved with reads and writes, which exposes a wrong decode priority. A held write, a word write and a byte write check single-pulse capture, address assembly and that only writes raise the captured flag.

// File: rtl/nvm_fe_pkg.sv
package nvm_fe_pkg;

   typedef enum logic [2:0] {
      OP_RESET   = 3'd0,
      OP_STANDBY = 3'd1,
      OP_DISABLE = 3'd2,
      OP_READ    = 3'd3,
      OP_WRITE   = 3'd4,
      OP_INVALID = 3'd5
   } bus_op_e;

   // Base pattern for lane k of the stand-in array: 8'h5A + k*8'h69
   localparam logic [7:0] STUB_SEED = 8'h5A;
   localparam logic [7:0] STUB_STEP = 8'h69;

endpackage

// File: rtl/nvm_op_decode.sv
module nvm_op_decode
   import nvm_fe_pkg::*;
(
   input  logic    ce_n,
   input  logic    oe_n,
   input  logic    we_n,
   input  logic    hw_rst_n,
   output bus_op_e op
);
   // Priority: reset pin, then chip enable, then the strobes
   always_comb begin
      if (!hw_rst_n)
         op = OP_RESET;
      else if (ce_n)
         op = OP_STANDBY;
      else if (oe_n)
         op = we_n ? OP_DISABLE : OP_WRITE;
      else
         op = we_n ? OP_READ : OP_INVALID;
   end
endmodule

// File: rtl/nvm_array_stub.sv
module nvm_array_stub
   import nvm_fe_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int IDX_W  = 4
) (
   input  logic [IDX_W-1:0]  idx,
   output logic [DATA_W-1:0] word
);
   localparam int LANES = DATA_W / 8;

   logic [7:0] idx8;
   assign idx8 = 8'(idx);

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      localparam logic [7:0] LANE_KEY = 8'(STUB_SEED + STUB_STEP * k);
      assign word[8*k +: 8] = idx8 ^ LANE_KEY;
   end
endmodule

// File: rtl/nvm_lane_steer.sv
module nvm_lane_steer #(
   parameter int DATA_W        = 16,
   parameter bit HAS_BYTE_MODE = 1'b1
) (
   input  logic [DATA_W-1:0] word,
   input  logic              drive,
   input  logic              byte_mode,
   input  logic              byte_sel,
   output logic [DATA_W-1:0] data,
   output logic [DATA_W-1:0] oe
);
   localparam int HALF_W = DATA_W / 2;

   if (HAS_BYTE_MODE) begin : g_dual
      always_comb begin
         data = '0;
         oe   = '0;
         if (drive) begin
            if (byte_mode) begin
               data[HALF_W-1:0] = byte_sel ? word[DATA_W-1:HALF_W]
                                           : word[HALF_W-1:0];
               oe[HALF_W-1:0]   = '1;
            end else begin
               data = word;
               oe   = '1;
            end
         end
      end
   end else begin : g_word_only
      logic unused_sel;
      assign unused_sel = byte_mode ^ byte_sel;
      assign data = drive ? word : '0;
      assign oe   = drive ? '1 : '0;
   end
endmodule

// File: rtl/nvm_cmd_capture.sv
module nvm_cmd_capture
   import nvm_fe_pkg::*;
#(
   parameter int WORD_ADDR_W = 19,
   parameter int DATA_W      = 16
) (
   input  logic                 clk,
   input  logic                 por_n,
   input  bus_op_e              op,
   input  logic                 byte_mode,
   input  logic [WORD_ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0]    dq_in,
   output logic                 cmd_valid,
   output logic [WORD_ADDR_W:0] cmd_addr,
   output logic [DATA_W-1:0]    cmd_data,
   output logic                 cmd_seen
);
   localparam int HALF_W = DATA_W / 2;

   logic wr_now, wr_prev, wr_first;

   assign wr_now   = (op == OP_WRITE);
   assign wr_first = wr_now && !wr_prev;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         wr_prev   <= 1'b0;
         cmd_valid <= 1'b0;
         cmd_addr  <= '0;
         cmd_data  <= '0;
         cmd_seen  <= 1'b0;
      end else begin
         wr_prev   <= wr_now;
         cmd_valid <= wr_first;
         if (wr_first) begin
            if (byte_mode) begin
               cmd_addr <= {addr, dq_in[DATA_W-1]};
               cmd_data <= {{HALF_W{1'b0}}, dq_in[HALF_W-1:0]};
            end else begin
               cmd_addr <= {1'b0, addr};
               cmd_data <= dq_in;
            end
         end
         if (op == OP_RESET)
            cmd_seen <= 1'b0;
         else if (wr_first)
            cmd_seen <= 1'b1;
      end
   end
endmodule

// File: rtl/nvm_bus_front.sv
module nvm_bus_front
   import nvm_fe_pkg::*;
#(
   parameter int WORD_ADDR_W   = 19,
   parameter int DATA_W        = 16,
   parameter int STUB_DEPTH    = 16,
   parameter bit HAS_BYTE_MODE = 1'b1
) (
   input  logic                   clk,
   input  logic                   por_n,
   input  logic                   ce_n,
   input  logic                   oe_n,
   input  logic                   we_n,
   input  logic                   hw_rst_n,
   input  logic                   wide_mode,
   input  logic [WORD_ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0]      dq_in,
   output logic [DATA_W-1:0]      dq_out,
   output logic [DATA_W-1:0]      dq_oe,
   output logic                   cmd_valid,
   output logic [WORD_ADDR_W:0]   cmd_addr,
   output logic [DATA_W-1:0]      cmd_data,
   output logic                   cmd_seen
);
   localparam int IDX_W = (STUB_DEPTH > 1) ? $clog2(STUB_DEPTH) : 1;

   if (DATA_W != 16) begin : g_bad_data_w
      $error("nvm_bus_front: DATA_W must be 16");
   end
   if (STUB_DEPTH < 2 || STUB_DEPTH > 256 || (STUB_DEPTH & (STUB_DEPTH - 1)) != 0) begin : g_bad_depth
      $error("nvm_bus_front: STUB_DEPTH must be a power of two in 2..256");
   end
   if (IDX_W > WORD_ADDR_W) begin : g_bad_addr_w
      $error("nvm_bus_front: WORD_ADDR_W too small for STUB_DEPTH");
   end

   bus_op_e          op;
   logic             byte_mode;
   logic [DATA_W-1:0] stub_word, steer_data, steer_oe;

   assign byte_mode = HAS_BYTE_MODE && !wide_mode;

   nvm_op_decode u_decode (
      .ce_n     (ce_n),
      .oe_n     (oe_n),
      .we_n     (we_n),
      .hw_rst_n (hw_rst_n),
      .op       (op)
   );

   nvm_array_stub #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_stub (
      .idx  (addr[IDX_W-1:0]),
      .word (stub_word)
   );

   nvm_lane_steer #(.DATA_W(DATA_W), .HAS_BYTE_MODE(HAS_BYTE_MODE)) u_steer (
      .word      (stub_word),
      .drive     (op == OP_READ),
      .byte_mode (byte_mode),
      .byte_sel  (dq_in[DATA_W-1]),
      .data      (steer_data),
      .oe        (steer_oe)
   );

   nvm_cmd_capture #(.WORD_ADDR_W(WORD_ADDR_W), .DATA_W(DATA_W)) u_cmd (
      .clk       (clk),
      .por_n     (por_n),
      .op        (op),
      .byte_mode (byte_mode),
      .addr      (addr),
      .dq_in     (dq_in),
      .cmd_valid (cmd_valid),
      .cmd_addr  (cmd_addr),
      .cmd_data  (cmd_data),
      .cmd_seen  (cmd_seen)
   );

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         dq_oe  <= '0;
         dq_out <= '0;
      end else begin
         dq_oe  <= steer_oe;
         dq_out <= steer_data;
      end
   end
endmodule

// File: rtl/nvm_bus_front_chk.sv
module nvm_bus_front_chk #(
   parameter int DATA_W        = 16,
   parameter bit HAS_BYTE_MODE = 1'b1
) (
   input logic              clk,
   input logic              por_n,
   input logic              ce_n,
   input logic              oe_n,
   input logic              we_n,
   input logic              hw_rst_n,
   input logic              wide_mode,
   input logic [DATA_W-1:0] dq_oe,
   input logic              cmd_valid,
   input logic              cmd_seen
);
   localparam logic [DATA_W-1:0] LOW_HALF = {{(DATA_W/2){1'b0}}, {(DATA_W/2){1'b1}}};

   p_word_lanes_r1: assert property (@(posedge clk) disable iff (!por_n)
      (!ce_n && !oe_n && we_n && hw_rst_n && wide_mode) |=> (&dq_oe));

   p_byte_lanes_r2: assert property (@(posedge clk) disable iff (!por_n)
      (HAS_BYTE_MODE && !ce_n && !oe_n && we_n && hw_rst_n && !wide_mode) |=> (dq_oe == LOW_HALF));

   p_disable_r3: assert property (@(posedge clk) disable iff (!por_n)
      (!ce_n && oe_n) |=> (dq_oe == '0));

   p_standby_r4: assert property (@(posedge clk) disable iff (!por_n)
      ce_n |=> (dq_oe == '0));

   p_reset_r5: assert property (@(posedge clk) disable iff (!por_n)
      !hw_rst_n |=> (dq_oe == '0 && !cmd_valid && !cmd_seen));

   p_single_pulse_r6: assert property (@(posedge clk) disable iff (!por_n)
      cmd_valid |=> !cmd_valid);

   p_seen_rise_r8: assert property (@(posedge clk) disable iff (!por_n)
      $rose(cmd_seen) |-> cmd_valid);

   p_invalid_r10: assert property (@(posedge clk) disable iff (!por_n)
      (!ce_n && !oe_n && !we_n && hw_rst_n) |=> (dq_oe == '0 && !cmd_valid));
endmodule

bind nvm_bus_front nvm_bus_front_chk #(
   .DATA_W        (DATA_W),
   .HAS_BYTE_MODE (HAS_BYTE_MODE)
) i_chk (
   .clk       (clk),
   .por_n     (por_n),
   .ce_n      (ce_n),
   .oe_n      (oe_n),
   .we_n      (we_n),
   .hw_rst_n  (hw_rst_n),
   .wide_mode (wide_mode),
   .dq_oe     (dq_oe),
   .cmd_valid (cmd_valid),
   .cmd_seen  (cmd_seen)
);

// File: tb/test_nvm_bus_front.sv
`timescale 1ns/1ps
module test_nvm_bus_front;
   localparam int AW    = 19;
   localparam int DW    = 16;
   localparam int DEPTH = 16;

   logic          clk = 1'b0;
   logic          por_n = 1'b0;
   logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, hw_rst_n = 1'b1, wide_mode = 1'b1;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] dq_in = '0;
   logic [DW-1:0] dq_out, dq_oe, cmd_data;
   logic          cmd_valid, cmd_seen;
   logic [AW:0]   cmd_addr;

   int    n_tests = 0, n_fail = 0;
   bit    chk_en = 1'b0, done = 1'b0;
   string tag = "R8";

   always #10 clk = ~clk;

   nvm_bus_front i_nvm_bus_front (
      .clk(clk), .por_n(por_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
      .hw_rst_n(hw_rst_n), .wide_mode(wide_mode), .addr(addr), .dq_in(dq_in),
      .dq_out(dq_out), .dq_oe(dq_oe), .cmd_valid(cmd_valid), .cmd_addr(cmd_addr),
      .cmd_data(cmd_data), .cmd_seen(cmd_seen)
   );

   // Behavioural reference model
   logic [DW-1:0] e_out, e_oe, e_cdata;
   logic [AW:0]   e_caddr;
   logic          e_valid, e_seen, m_prev_wr;

   function automatic logic [DW-1:0] ref_word(int a);
      int i = a % DEPTH;
      return {8'((i ^ 'hC3) & 255), 8'((i ^ 'h5A) & 255)};
   endfunction

   always @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         e_out <= '0; e_oe <= '0; e_cdata <= '0; e_caddr <= '0;
         e_valid <= 1'b0; e_seen <= 1'b0; m_prev_wr <= 1'b0;
      end else begin
         bit rd, wr, bm;
         logic [DW-1:0] w;
         rd = !ce_n && !oe_n && we_n && hw_rst_n;
         wr = !ce_n && oe_n && !we_n && hw_rst_n;
         bm = !wide_mode;
         w  = ref_word(int'(addr));
         e_oe  <= !rd ? 16'h0000 : (bm ? 16'h00FF : 16'hFFFF);
         e_out <= !rd ? 16'h0000 : (bm ? {8'h00, (dq_in[15] ? w[15:8] : w[7:0])} : w);
         e_valid   <= wr && !m_prev_wr;
         m_prev_wr <= wr;
         if (wr && !m_prev_wr) begin
            e_caddr <= bm ? {addr, dq_in[15]} : {1'b0, addr};
            e_cdata <= bm ? {8'h00, dq_in[7:0]} : dq_in;
         end
         if (!hw_rst_n) e_seen <= 1'b0;
         else if (wr && !m_prev_wr) e_seen <= 1'b1;
      end
   end

   always @(negedge clk) begin
      if (chk_en && !done) begin
         n_tests++;
         if (dq_oe !== e_oe || dq_out !== e_out || cmd_valid !== e_valid ||
             cmd_seen !== e_seen || cmd_addr !== e_caddr || cmd_data !== e_cdata) begin
            n_fail++;
            $display("FAIL %s: oe=%h out=%h v=%b seen=%b ca=%h cd=%h exp oe=%h out=%h v=%b seen=%b ca=%h cd=%h",
                     tag, dq_oe, dq_out, cmd_valid, cmd_seen, cmd_addr, cmd_data,
                     e_oe, e_out, e_valid, e_seen, e_caddr, e_cdata);
         end
      end
   end

   task automatic drv(input string t, input logic c, input logic o, input logic w,
                      input logic r, input logic wide, input logic [AW-1:0] a,
                      input logic [DW-1:0] d, input int n);
      @(negedge clk);
      tag = t;
      ce_n = c; oe_n = o; we_n = w; hw_rst_n = r; wide_mode = wide; addr = a; dq_in = d;
      repeat (n - 1) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      por_n = 1'b1;
      chk_en = 1'b1;
      drv("R8", 1, 1, 1, 1, 1, '0, '0, 2);                 // reset state, standby
      drv("R9", 0, 0, 1, 1, 1, 19'd3, '0, 2);              // first read, no command
      drv("R1", 0, 0, 1, 1, 1, 19'd0, '0, 1);
      drv("R1", 0, 0, 1, 1, 1, 19'd15, '0, 1);
      drv("R1", 0, 0, 1, 1, 1, 19'd21, '0, 1);
      drv("R1", 0, 0, 1, 1, 1, 19'h7FFFF, '0, 2);
      drv("R2", 0, 0, 1, 1, 0, 19'd6, 16'h0000, 1);        // low byte
      drv("R2", 0, 0, 1, 1, 0, 19'd6, 16'h8000, 1);        // high byte
      drv("R2", 0, 0, 1, 1, 0, 19'd13, 16'hFFFF, 2);
      drv("R3", 0, 1, 1, 1, 1, 19'd4, '0, 2);
      drv("R4", 1, 0, 1, 1, 1, 19'd4, '0, 1);
      drv("R4", 1, 1, 0, 1, 1, 19'd4, 16'h1234, 2);        // strobes with chip off
      drv("R10", 0, 0, 0, 1, 1, 19'd5, 16'hBEEF, 2);
      drv("R8", 0, 0, 1, 1, 1, 19'd2, '0, 1);              // read must not set flag
      drv("R6", 0, 1, 0, 1, 1, 19'h2A5C3, 16'hA55A, 4);    // held word write
      drv("R7", 0, 1, 1, 1, 1, 19'h2A5C3, '0, 2);
      drv("R7", 0, 1, 0, 1, 0, 19'h1F00F, 16'h80C7, 2);    // byte write, LSB=1
      drv("R7", 0, 1, 1, 1, 0, 19'h1F00F, '0, 1);
      drv("R7", 0, 1, 0, 1, 0, 19'h00011, 16'h7F3E, 1);    // byte write, LSB=0
      drv("R6", 0, 1, 1, 1, 1, '0, '0, 2);
      drv("R5", 0, 0, 1, 0, 1, 19'd7, '0, 1);              // reset overrides read
      drv("R5", 0, 1, 0, 0, 1, 19'd7, 16'h1111, 2);        // reset overrides write
      drv("R9", 0, 0, 1, 1, 0, 19'd9, 16'h8000, 2);        // read after reset
      drv("R1", 0, 0, 1, 1, 1, 19'd9, '0, 2);
      drv("R4", 1, 1, 1, 1, 1, '0, '0, 2);
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #(20 * 5000);
      if (!done) begin
         done = 1'b1;
         n_fail++;
         n_tests++;
         $display("FAIL watchdog: run did not complete, actual=hung expected=done");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule